// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The block walks a chain of command packets held in system memory. Each node starts with one header word. That word gives the number of payload words that follow it and the address of the next node. The walker reads the header and passes each payload word to a drawing port over a valid/ready stream. It then jumps to the next node. The walk stops when the current node address carries an end flag.

While it walks, the walker keeps a running estimate of what the chain costs in processor cycles. The estimate grows by a fixed amount per node, plus a surcharge for each node that carries payload. When the walk ends, a one-cycle completion pulse marks it, and the estimate is held for software or a scheduler to read.

The memory port is word-addressed and has a fixed read latency of one cycle. A start pulse loads the first node address. While a walk is under way, further start pulses are ignored.

Top module: `dma_chain_walker`

## Requirements
- R1: In a header word, bits 31:24 give the payload length and bits 23:0 give the next-node pointer. The payload is the length words that directly follow the header, forwarded in rising address order. A length of zero forwards no word.
- R2: An accepted start loads the start address masked to its low 24 bits. Before each header read, the current address is tested. If its bit 23 is set, the walk ends with no further memory read, and this applies to the start address too.
- R3: A node address is used as a byte address after masking to bits 20:0. The memory word address is bits 20:2 of that byte address, so address bits 22:21 have no effect.
- R4: An accepted start clears the cycle estimate. Each node visited adds 10, and a node with a non-zero length adds a further 5 plus its length. The estimate holds its value after the walk until the next accepted start.
- R5: `done_o` is high for exactly one cycle, in the cycle after the terminating address is seen. It pulses once per walk.
- R6: A start pulse that arrives while a walk is in progress has no effect on the stream, the estimate or the completion pulse.
- R7: A payload word transfers when `out_valid_o` and `out_ready_i` are both high. While valid is high and ready is low, valid stays high and the data does not change.
- R8: After reset, `done_o`, `out_valid_o` and `mem_rd_o` are low and `cycles_o` is zero.
- R9: Read data is taken from `mem_rdata_i` in the cycle after `mem_rd_o` was high. In any cycle, at most one of `mem_rd_o`, `out_valid_o` and `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| start_addr_i | input | 32 | First node address; the low 24 bits are used |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 19 | Memory word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the strobe |
| out_valid_o | output | 1 | Payload word valid |
| out_ready_i | input | 1 | Drawing port ready |
| out_data_o | output | 32 | Payload word |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| cycles_o | output | 32 | Cycle-cost estimate |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a walk while the stream is stalled. If that pulse were taken, it would restart the walk and corrupt both the estimate and the word order. The bench launches a multi-node chain, lets the ready line stall it, and then pulses start with an address that would end at once. It confirms that the original chain's five words, its cost of 45 and its single done pulse all survive. Address masking is reached through a start address and a next pointer whose bits 22:21 are set; these must land on the same nodes as when those bits are clear.

// File: rtl/dma_chain_walker_pkg.sv
package dma_chain_walker_pkg;

    typedef enum logic [2:0] {
        CW_IDLE,
        CW_CHECK,
        CW_HDR,
        CW_PRD,
        CW_PCAP,
        CW_POUT
    } cw_state_e;

endpackage

// File: rtl/dcw_hdr_decode.sv
module dcw_hdr_decode #(
    parameter int DATA_W    = 32,
    parameter int PTR_W     = 24,
    parameter int LEN_W     = 8,
    parameter int COST_W    = 32,
    parameter int NODE_COST = 10,
    parameter int PAY_COST  = 5
) (
    input  logic [DATA_W-1:0] hdr_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [PTR_W-1:0]  next_o,
    output logic [COST_W-1:0] cost_o
);
    localparam int LEN_LSB = DATA_W - LEN_W;

    always_comb begin
        len_o  = hdr_i[DATA_W-1:LEN_LSB];
        next_o = hdr_i[PTR_W-1:0];
        cost_o = COST_W'(NODE_COST);
        if (len_o != '0) begin
            cost_o = cost_o + COST_W'(PAY_COST) + COST_W'(len_o);
        end
    end

    logic unused_hdr;
    if (LEN_LSB > PTR_W) begin : g_gap
        assign unused_hdr = ^hdr_i[LEN_LSB-1:PTR_W];
    end else begin : g_nogap
        assign unused_hdr = 1'b0;
    end
endmodule

// File: rtl/dcw_cost_acc.sv
module dcw_cost_acc #(
    parameter int COST_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [COST_W-1:0] val_i,
    output logic [COST_W-1:0] total_o
);
    logic [COST_W-1:0] total_d, total_q;

    always_comb begin
        total_d = total_q;
        if (clr_i) begin
            total_d = '0;
        end else if (add_i) begin
            total_d = total_q + val_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) total_q <= '0;
        else         total_q <= total_d;
    end

    assign total_o = total_q;

    // R4
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (total_o == '0));
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dma_chain_walker_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PTR_W     = 24,
    parameter int END_BIT   = 23,
    parameter int BYTE_AW   = 21,
    parameter int LEN_W     = 8,
    parameter int COST_W    = 32,
    parameter int NODE_COST = 10,
    parameter int PAY_COST  = 5,
    localparam int WORD_AW  = BYTE_AW - 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  start_addr_i,
    output logic               mem_rd_o,
    output logic [WORD_AW-1:0] mem_addr_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [DATA_W-1:0]  out_data_o,
    output logic               done_o,
    output logic [COST_W-1:0]  cycles_o
);
    typedef struct packed {
        cw_state_e          st;
        logic [PTR_W-1:0]   cur;
        logic [PTR_W-1:0]   nxt;
        logic [WORD_AW-1:0] ptr;
        logic [LEN_W-1:0]   rem;
        logic [DATA_W-1:0]  odata;
        logic               ovalid;
        logic               done;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0]  hdr_len;
    logic [PTR_W-1:0]  hdr_next;
    logic [COST_W-1:0] hdr_cost;
    logic              cost_clr, cost_add;

    dcw_hdr_decode #(
        .DATA_W(DATA_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .COST_W(COST_W),
        .NODE_COST(NODE_COST), .PAY_COST(PAY_COST)
    ) u_hdr (
        .hdr_i (mem_rdata_i),
        .len_o (hdr_len),
        .next_o(hdr_next),
        .cost_o(hdr_cost)
    );

    dcw_cost_acc #(.COST_W(COST_W)) u_cost (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cost_clr),
        .add_i  (cost_add),
        .val_i  (hdr_cost),
        .total_o(cycles_o)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        mem_rd_o   = 1'b0;
        mem_addr_o = q.ptr;
        cost_clr   = 1'b0;
        cost_add   = 1'b0;
        case (q.st)
            CW_IDLE: begin
                if (start_i) begin
                    d.cur    = start_addr_i[PTR_W-1:0];
                    cost_clr = 1'b1;
                    d.st     = CW_CHECK;
                end
            end
            CW_CHECK: begin
                if (q.cur[END_BIT]) begin
                    d.done = 1'b1;
                    d.st   = CW_IDLE;
                end else begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = q.cur[BYTE_AW-1:2];
                    d.ptr      = q.cur[BYTE_AW-1:2] + WORD_AW'(1);
                    d.st       = CW_HDR;
                end
            end
            CW_HDR: begin
                cost_add = 1'b1;
                d.nxt    = hdr_next;
                d.rem    = hdr_len;
                if (hdr_len == '0) begin
                    d.cur = hdr_next;
                    d.st  = CW_CHECK;
                end else begin
                    d.st  = CW_PRD;
                end
            end
            CW_PRD: begin
                mem_rd_o = 1'b1;
                d.st     = CW_PCAP;
            end
            CW_PCAP: begin
                d.odata  = mem_rdata_i;
                d.ovalid = 1'b1;
                d.st     = CW_POUT;
            end
            CW_POUT: begin
                if (out_ready_i) begin
                    d.ovalid = 1'b0;
                    d.ptr    = q.ptr + WORD_AW'(1);
                    d.rem    = q.rem - LEN_W'(1);
                    if (q.rem == LEN_W'(1)) begin
                        d.cur = q.nxt;
                        d.st  = CW_CHECK;
                    end else begin
                        d.st  = CW_PRD;
                    end
                end
            end
            default: d.st = CW_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: CW_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign out_valid_o = q.ovalid;
    assign out_data_o  = q.odata;
    assign done_o      = q.done;

    logic unused_bits;
    assign unused_bits = ^{start_addr_i[DATA_W-1:PTR_W], q.cur[END_BIT-1:BYTE_AW],
                           q.cur[1:0]};

    // R7
    out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R5
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({mem_rd_o, out_valid_o, done_o}));

    // R4
    cost_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == CW_IDLE && !start_i) |=> $stable(cycles_o));

    // R2
    end_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == CW_CHECK && q.cur[END_BIT]) |=> (done_o && !mem_rd_o));
endmodule

// File: tb/dma_chain_walker_tb.sv
`timescale 1ns/1ps
module dma_chain_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_rd;
    logic [18:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        done;
    logic [31:0] cycles;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dma_chain_walker u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
        .done_o(done), .cycles_o(cycles)
    );

    logic [31:0] mem [0:1023];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= (mem_addr[18:10] == '0) ? mem[mem_addr[9:0]] : 32'h0;
    end

    // stimulus vectors: start address, expected words, expected cost, tag base
    localparam logic [127:0] VECS [0:4] = '{
        {32'h0000_0100, 32'd5,   32'd45,  32'hA000_0000},
        {32'h5F60_0400, 32'd2,   32'd32,  32'hB000_0000},
        {32'h0080_0000, 32'd0,   32'd0,   32'hC000_0000},
        {32'h0000_0600, 32'd0,   32'd20,  32'hD000_0000},
        {32'h0000_0800, 32'd255, 32'd270, 32'hE000_0000}
    };

    logic [31:0] exp_base = '0;
    int rx_cnt = 0, order_err = 0, done_cnt = 0, hold_err = 0, excl_err = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && (!out_valid || out_data != prev_data)) hold_err++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if ((32'(mem_rd) + 32'(out_valid) + 32'(done)) > 1) excl_err++;
            if (out_valid && out_ready) begin
                if (out_data != exp_base + 32'(rx_cnt)) order_err++;
                rx_cnt++;
            end
            if (done) done_cnt++;
        end
    end

    int rdy_cnt = 0;
    logic stall_en = 1'b0;
    initial begin
        forever begin
            @(posedge clk); #2;
            rdy_cnt++;
            out_ready = stall_en ? (rdy_cnt % 3 != 0) : 1'b1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [31:0] a);
        @(posedge clk); #2;
        start_addr = a; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk); #1;
            if (done) seen = 1'b1;
        end
    endtask

    task automatic clear_mon(input logic [31:0] base);
        exp_base = base; rx_cnt = 0; order_err = 0; done_cnt = 0;
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        // chain A
        mem[10'h040] = {8'd2, 24'h000200};
        mem[10'h041] = 32'hA000_0000; mem[10'h042] = 32'hA000_0001;
        mem[10'h080] = {8'd0, 24'h000300};
        mem[10'h0C0] = {8'd3, 24'h800000};
        mem[10'h0C1] = 32'hA000_0002; mem[10'h0C2] = 32'hA000_0003;
        mem[10'h0C3] = 32'hA000_0004;
        // chain B, masked address bits set
        mem[10'h100] = {8'd1, 24'h200500};
        mem[10'h101] = 32'hB000_0000;
        mem[10'h140] = {8'd1, 24'hFFFFFF};
        mem[10'h141] = 32'hB000_0001;
        // chain D, empty nodes
        mem[10'h180] = {8'd0, 24'h000700};
        mem[10'h1C0] = {8'd0, 24'h800000};
        // chain E, maximum length
        mem[10'h200] = {8'd255, 24'h900000};
        for (int k = 0; k < 255; k++) mem[10'h201 + k] = 32'hE000_0000 + 32'(k);

        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 done", int'(done), 0);
        check("R8 valid", int'(out_valid), 0);
        check("R8 mem_rd", int'(mem_rd), 0);
        check("R8 cycles", int'(cycles), 0);

        stall_en = 1'b1;
        for (int v = 0; v < 5; v++) begin
            logic [31:0] sa, ew, ec, tb;
            {sa, ew, ec, tb} = VECS[v];
            clear_mon(tb);
            pulse_start(sa);
            wait_done(seen);
            check("R5 done seen", int'(seen), 1);
            check("R1 word count", rx_cnt, int'(ew));
            check("R1 R3 order", order_err, 0);
            check("R4 cost", int'(cycles), int'(ec));
            check("R2 R5 single done", done_cnt, 1);
            repeat (3) @(negedge clk);
        end

        // R6: start during walk is ignored
        clear_mon(32'hA000_0000);
        pulse_start(32'h0000_0100);
        repeat (6) @(posedge clk);
        pulse_start(32'h0080_0000);
        wait_done(seen);
        check("R6 done seen", int'(seen), 1);
        check("R6 word count", rx_cnt, 5);
        check("R6 order", order_err, 0);
        check("R6 cost", int'(cycles), 45);
        repeat (20) @(negedge clk);
        #1;
        check("R4 cost held", int'(cycles), 45);
        check("R5 one pulse", done_cnt, 1);
        check("R7 idle valid", int'(out_valid), 0);
        check("R7 stall hold", hold_err, 0);
        check("R9 exclusive", excl_err, 0);

        // R4: next start clears the estimate (end-at-start chain)
        pulse_start(32'h00FF_FFFF);
        wait_done(seen);
        check("R2 end at start", int'(seen), 1);
        check("R4 cleared", int'(cycles), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule